// File: doc/BRIEF.md
# SPI Word Slave with Per-Word Select Framing

This block is the receive and transmit engine of an SPI slave port. It runs on a fast system clock and treats the external serial clock, slave select and MOSI lines as asynchronous inputs. Each of these passes through a two-flop synchronizer before use. Serial clock edges are found by comparing successive synchronized samples, so the system clock must run at least four times the serial clock rate. Words are 16 bits long and travel MSB first in both directions. Both idle clock levels and both clock phases are supported.

On the parallel side, a transmit holding register is written with a load strobe. The engine copies it into the shifter when a word starts. A completed word appears on a receive register together with a single-cycle valid pulse. Phase and polarity are copied from their configuration inputs only while the enable input is low, and are frozen while the block is enabled. The MISO data output comes with an output-enable that a pad driver uses to release the line.

In phase-0 mode, the falling edge of select starts the word and places the MSB on MISO before any clock edge arrives. Select must then rise and fall again before the next word. In phase-1 mode, the first edge of each word puts out the MSB, and several words may follow one another under one held select.

The engine has four states:
- OFF: disabled.
- WAIT: enabled, select high.
- XFER: shifting.
- HOLD: a phase-0 word is complete and the engine waits for select to rise.

The transitions are:
- Any state goes to OFF when enable falls.
- OFF goes to WAIT when the block is enabled with select high.
- WAIT goes to XFER when select falls.
- XFER goes to WAIT when select rises early. The partial word is discarded.
- XFER goes to HOLD on the 16th sample edge in phase 0.
- XFER stays in XFER after the 16th sample edge in phase 1.
- HOLD goes to WAIT when select rises.

Top module: `spi_word_slave`

## Requirements
- R1: A word is 16 bits long and is shifted MSB first on both MOSI and MISO. The received word appears with its first received bit at rx_data[15].
- R2: Polarity setting 0 means SCLK idles low, so the leading edge is a rise. Polarity setting 1 means SCLK idles high, so the leading edge is a fall. Polarity changes only which edges count as leading and trailing.
- R3: With phase setting 0, a falling edge of select places bit 15 of the transmit word on MISO before the first SCLK edge. MOSI is sampled on leading (odd-numbered) edges, and MISO advances on trailing (even-numbered) edges.
- R4: With phase setting 1, each leading edge puts out the next MISO bit and each trailing edge samples MOSI. The first leading edge of a word loads the transmit word. Words may follow back to back while select stays low, and each word takes the transmit register value present at its start.
- R5: After the 16th sample edge, rx_data takes the received word and rx_valid is high for exactly one system clock cycle.
- R6: With phase setting 0, once a word completes, further SCLK edges with select still low produce no data. A new word needs select to rise and then fall.
- R7: cfg_cpol and cfg_cpha are accepted only while cfg_en is low. Changes while cfg_en is high have no effect on the transfer.
- R8: If select rises before 16 bits are sampled, the partial word is discarded and no valid pulse is produced. The next word is received correctly from bit 15.
- R9: miso_oe is 1 only while the block is enabled and a word frame is in progress with select low. Otherwise it is 0.
- R10: Clearing cfg_en during a word drops miso_oe in the same cycle and clears the shift state. After re-enabling, the next word is correct.
- R11: After reset, rx_valid, miso_oe and rx_data are all 0.
- R12: A tx_load pulse stores tx_data into the transmit register. The value stored last before a word starts is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable; configuration is accepted only while low |
| cfg_cpol | input | 1 | Clock idle level (1 = idles high) |
| cfg_cpha | input | 1 | Clock phase (0 = sample on leading edge) |
| tx_data | input | 16 | Next transmit word |
| tx_load | input | 1 | Stores tx_data into the transmit register |
| rx_data | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| ss_n | input | 1 | Slave select, active low (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for MISO; 0 means high impedance |

## Verification
A wrong bit counter or a wrong state shows up at the ports within one word. The valid pulse then arrives after the wrong number of edges, or is missing, or repeats while select is held in phase 0. A wrong choice of leading or trailing edge shifts every MISO bit the master captures by one position, and this corrupts the received word from its first bit. Leftover shift state after an aborted word or a disable shows as a corrupted next word. A missed release shows as miso_oe staying high in the cycle enable is cleared.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_WAIT = 2'd1,
        S_XFER = 2'd2,
        S_HOLD = 2'd3
    } slv_state_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic ss_n_in,
    input  logic mosi_in,
    output logic sclk_lvl,
    output logic sclk_prev,
    output logic ss_lvl,
    output logic mosi_lvl
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stage_q [STAGES];
    logic [NSIG-1:0] raw_in;

    assign raw_in = {ss_n_in, sclk_in, mosi_in};

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 3'b100;
                    else        stage_q[g] <= raw_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 3'b100;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= stage_q[STAGES-1][1];
    end

    assign ss_lvl   = stage_q[STAGES-1][2];
    assign sclk_lvl = stage_q[STAGES-1][1];
    assign mosi_lvl = stage_q[STAGES-1][0];
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sclk_lvl,
    input  logic              sclk_prev,
    input  logic              ss_lvl,
    input  logic              mosi_lvl,
    input  logic [WORD_W-1:0] tx_hold,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              miso,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    slv_state_t state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              miso_q;
    logic              loaded;

    logic rise_ev, fall_ev, lead_ev, trail_ev, sample_ev, shift_ev, word_end;

    assign rise_ev   = sclk_lvl & ~sclk_prev;
    assign fall_ev   = ~sclk_lvl & sclk_prev;
    assign lead_ev   = cpol ? fall_ev : rise_ev;
    assign trail_ev  = cpol ? rise_ev : fall_ev;
    assign sample_ev = cpha ? trail_ev : lead_ev;
    assign shift_ev  = cpha ? lead_ev : trail_ev;
    assign word_end  = sample_ev && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:  if (ss_lvl) state_nx = S_WAIT;
            S_WAIT: if (!ss_lvl) state_nx = S_XFER;
            S_XFER: begin
                if (ss_lvl)                 state_nx = S_WAIT;
                else if (word_end && !cpha) state_nx = S_HOLD;
            end
            S_HOLD: if (ss_lvl) state_nx = S_WAIT;
            default: state_nx = S_OFF;
        endcase
        if (!en) state_nx = S_OFF;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            miso_q   <= 1'b0;
            loaded   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (!en) begin
            cnt      <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            miso_q   <= 1'b0;
            loaded   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                S_WAIT: begin
                    if (!ss_lvl) begin
                        cnt    <= '0;
                        loaded <= 1'b0;
                        if (!cpha) begin
                            miso_q <= tx_hold[WORD_W-1];
                            tx_sh  <= tx_hold << 1;
                            loaded <= 1'b1;
                        end
                    end
                end
                S_XFER: begin
                    if (ss_lvl) begin
                        cnt    <= '0;
                        loaded <= 1'b0;
                    end else begin
                        if (shift_ev) begin
                            if (!loaded) begin
                                miso_q <= tx_hold[WORD_W-1];
                                tx_sh  <= tx_hold << 1;
                                loaded <= 1'b1;
                            end else begin
                                miso_q <= tx_sh[WORD_W-1];
                                tx_sh  <= tx_sh << 1;
                            end
                        end
                        if (sample_ev) begin
                            rx_sh <= {rx_sh[WORD_W-2:0], mosi_lvl};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST) begin
                                rx_data  <= {rx_sh[WORD_W-2:0], mosi_lvl};
                                rx_valid <= 1'b1;
                                cnt      <= '0;
                                if (cpha) loaded <= 1'b0;
                            end
                        end
                    end
                end
                S_OFF, S_HOLD: ;
                default: ;
            endcase
        end
    end

    assign miso_oe = en && ((state == S_XFER) || (state == S_HOLD));
    assign miso    = miso_oe & miso_q;

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_from_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) == S_XFER);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == S_OFF) && (cnt == '0) && !rx_valid);

    assert_oe_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT || state == S_OFF) |-> !miso_oe);

    assert_hold_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && en && !ss_lvl) |=> !rx_valid);
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
    parameter int WORD_W    = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              sclk,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe
);
    logic              lat_cpol, lat_cpha;
    logic [WORD_W-1:0] tx_hold;
    logic              sclk_lvl, sclk_prev, ss_lvl, mosi_lvl;

    // configuration is only sampled while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cpol <= 1'b0;
            lat_cpha <= 1'b0;
        end else if (!cfg_en) begin
            lat_cpol <= cfg_cpol;
            lat_cpha <= cfg_cpha;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_hold <= '0;
        else if (tx_load) tx_hold <= tx_data;
    end

    spi_slv_sync #(.STAGES(SYNC_STGS)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk),
        .ss_n_in   (ss_n),
        .mosi_in   (mosi),
        .sclk_lvl  (sclk_lvl),
        .sclk_prev (sclk_prev),
        .ss_lvl    (ss_lvl),
        .mosi_lvl  (mosi_lvl)
    );

    spi_slv_engine #(.WORD_W(WORD_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .cpol      (lat_cpol),
        .cpha      (lat_cpha),
        .sclk_lvl  (sclk_lvl),
        .sclk_prev (sclk_prev),
        .ss_lvl    (ss_lvl),
        .mosi_lvl  (mosi_lvl),
        .tx_hold   (tx_hold),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && $past(cfg_en)) |-> ($stable(lat_cpol) && $stable(lat_cpha)));

    assert_tx_hold_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> tx_hold == $past(tx_data));
endmodule

// File: tb/test_spi_word_slave.sv
module test_spi_word_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_load = 1'b0;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_word_slave i_spi_word_slave (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .ss_n(ss_n),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    always @(posedge clk) if (rx_valid) pulses <= pulses + 1;

    // {cpol, cpha, tx word, mosi word}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 16'hA5C3, 16'h1234},
        {1'b1, 1'b0, 16'h8001, 16'hFFFE},
        {1'b0, 1'b1, 16'h7E18, 16'hC0DE},
        {1'b1, 1'b1, 16'h0F0F, 16'h8000},
        {1'b0, 1'b0, 16'hFFFF, 16'h0001},
        {1'b1, 1'b1, 16'h5A5A, 16'h3C96}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic pol, input logic pha);
        cfg_en = 1'b0;
        wt(2);
        cfg_cpol = pol;
        cfg_cpha = pha;
        sclk = pol;
        ss_n = 1'b1;
        wt(4);
        cfg_en = 1'b1;
        wt(4);
    endtask

    task automatic load_tx(input logic [15:0] v);
        tx_data = v;
        tx_load = 1'b1;
        wt(1);
        tx_load = 1'b0;
    endtask

    // master side; phase/polarity of the master passed explicitly
    task automatic xfer(input logic pol, input logic pha, input logic [15:0] mw,
                        input int nbits, output logic [15:0] got);
        got = '0;
        if (ss_n) begin
            ss_n = 1'b0;
            if (!pha) mosi = mw[15];
            wt(8);
        end else if (!pha) begin
            mosi = mw[15];
        end
        for (int i = 0; i < nbits; i++) begin
            if (!pha) begin
                got[15-i] = miso;
                sclk = ~pol;
                wt(8);
                sclk = pol;
                if (i < 15) mosi = mw[14-i];
                wt(8);
            end else begin
                sclk = ~pol;
                mosi = mw[15-i];
                wt(8);
                got[15-i] = miso;
                sclk = pol;
                wt(8);
            end
        end
    endtask

    task automatic ss_up;
        ss_n = 1'b1;
        wt(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        int p0;
        wt(3);
        // R11 reset state
        chk("R11 rx_valid", rx_valid, 0);
        chk("R11 miso_oe", miso_oe, 0);
        chk("R11 rx_data", rx_data, 0);
        rst_n = 1'b1;
        wt(2);

        // vector table: R1 R2 R3 R4 R5 R12
        foreach (VEC[k]) begin
            setup(VEC[k][33], VEC[k][32]);
            load_tx(VEC[k][31:16]);
            p0 = pulses;
            xfer(VEC[k][33], VEC[k][32], VEC[k][15:0], 16, got);
            chk("R9 oe during word", miso_oe, 1);
            ss_up();
            chk("R1 rx word", rx_data, VEC[k][15:0]);
            chk(VEC[k][32] ? "R4 miso word" : "R3 miso word", got, VEC[k][31:16]);
            chk("R5 one pulse", pulses - p0, 1);
            chk("R9 oe after ss high", miso_oe, 0);
        end

        // R3: MSB present after select falls, before any clock edge
        setup(1'b0, 1'b0);
        load_tx(16'h8000);
        ss_n = 1'b0;
        wt(8);
        chk("R3 msb before edge", {miso_oe, miso}, 2'b11);
        ss_up();

        // R6: phase 0, extra clocks with select still low give no word
        setup(1'b0, 1'b0);
        load_tx(16'h1357);
        p0 = pulses;
        xfer(1'b0, 1'b0, 16'hBEEF, 16, got);
        xfer(1'b0, 1'b0, 16'h0000, 16, got);
        chk("R6 no second pulse", pulses - p0, 1);
        chk("R6 rx kept", rx_data, 16'hBEEF);
        ss_up();

        // R4: phase 1 back to back, new transmit word per word
        setup(1'b1, 1'b1);
        load_tx(16'hAAAA);
        p0 = pulses;
        xfer(1'b1, 1'b1, 16'h1111, 16, got);
        chk("R4 first miso", got, 16'hAAAA);
        load_tx(16'h6C3B);
        xfer(1'b1, 1'b1, 16'h2222, 16, got);
        chk("R4 second miso", got, 16'h6C3B);
        chk("R4 second rx", rx_data, 16'h2222);
        chk("R4 two pulses", pulses - p0, 2);
        ss_up();

        // R12: last load before start wins
        setup(1'b0, 1'b1);
        load_tx(16'h0101);
        load_tx(16'hF00D);
        xfer(1'b0, 1'b1, 16'h4444, 16, got);
        ss_up();
        chk("R12 last load", got, 16'hF00D);

        // R8: early select rise
        setup(1'b0, 1'b0);
        load_tx(16'h9999);
        p0 = pulses;
        xfer(1'b0, 1'b0, 16'hFFFF, 8, got);
        ss_up();
        chk("R8 no pulse", pulses - p0, 0);
        xfer(1'b0, 1'b0, 16'h5A0F, 16, got);
        ss_up();
        chk("R8 next word", rx_data, 16'h5A0F);
        chk("R8 next miso", got, 16'h9999);

        // R7: polarity change while enabled ignored
        setup(1'b0, 1'b0);
        load_tx(16'hC3C3);
        @(negedge clk);
        cfg_cpol = 1'b1;
        cfg_cpha = 1'b1;
        wt(4);
        xfer(1'b0, 1'b0, 16'h7171, 16, got);
        ss_up();
        chk("R7 rx with old cfg", rx_data, 16'h7171);
        chk("R7 miso with old cfg", got, 16'hC3C3);

        // R10: disable mid-word
        setup(1'b0, 1'b0);
        load_tx(16'hE7E7);
        p0 = pulses;
        xfer(1'b0, 1'b0, 16'hFFFF, 6, got);
        cfg_en = 1'b0;
        #1;
        chk("R10 oe drops at once", miso_oe, 0);
        wt(4);
        ss_up();
        chk("R10 no pulse", pulses - p0, 0);
        setup(1'b0, 1'b0);
        xfer(1'b0, 1'b0, 16'h2468, 16, got);
        ss_up();
        chk("R10 word after re-enable", rx_data, 16'h2468);
        chk("R10 miso after re-enable", got, 16'hE7E7);

        // R9: disabled with select low keeps miso released
        cfg_en = 1'b0;
        ss_n = 1'b0;
        wt(8);
        chk("R9 oe off when disabled", miso_oe, 0);
        ss_n = 1'b1;
        wt(4);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule